// File: doc/BRIEF.md
# Carry-Select Accumulating Counter

This block is a parameterised arithmetic register built on a ripple of one-bit slices. Each slice carries two carry lines. One line assumes that the chain was entered with a carry of 0, and the other assumes a carry of 1. At every bit the true entry carry picks the line that feeds the sum. Because of this, the entry carry can arrive late without holding up the lines themselves.

A result register sits around the chain. It acts as an up/down counter when the count enable is high. It acts as an add/subtract accumulator when the accumulate enable is high. The chain's output is also brought out unregistered, together with the final carry.

The add/subtract control reaches the chain only as the entry carry of the first slice. When subtracting, that carry is 1 and the operand is inverted, which together form the two's complement. Counting reuses the same chain. Counting up adds zero with an entry carry of 1. Counting down adds all ones with an entry carry of 0.

Top module: `cscAccumCounter`

## Requirements
- R1: Each slice forms two carry outputs, one for an assumed incoming carry of 0 and one for 1, each chosen by its own incoming line; the first slice receives 0 and 1 on those lines, and the entry carry selects which line drives each sum bit and the final carry.
- R2: With accEn high, cntEn low and addSub = 1, combResult equals (result + operand) mod 2^WIDTH and carryOut equals bit WIDTH of the full sum.
- R3: With accEn high, cntEn low and addSub = 0, combResult equals (result - operand) mod 2^WIDTH and carryOut is 1 exactly when result >= operand (no borrow).
- R4: With cntEn high, combResult is result + 1 when countUp = 1 and result - 1 when countUp = 0; carryOut is 1 when counting up from all ones, and it is 0 when counting down from zero and 1 otherwise.
- R5: When the register steps, it takes at the clock edge the value shown on combResult just before that edge.
- R6: With clkEn high, syncClr forces result to 0 at the next edge, over load, count and accumulate.
- R7: With clkEn high and syncClr low, syncLoad writes loadVal into result, over count and accumulate.
- R8: With clkEn low, result holds whatever the other controls are.
- R9: cntEn takes precedence over accEn; with neither high, and no clear or load, result holds.
- R10: asyncClr drives result to 0 at once, without waiting for a clock edge.
- R11: With the default WIDTH of 8, counting wraps from 0xFF to 0x00 going up and from 0x00 to 0xFF going down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| asyncClr | input | 1 | Asynchronous clear of the result register, active high |
| clkEn | input | 1 | Clock enable for every register update except the asynchronous clear |
| cntEn | input | 1 | Selects counting by one |
| countUp | input | 1 | Count direction: 1 up, 0 down |
| accEn | input | 1 | Selects accumulating the operand |
| addSub | input | 1 | Accumulate direction: 1 add, 0 subtract |
| syncClr | input | 1 | Synchronous clear |
| syncLoad | input | 1 | Synchronous load of loadVal |
| loadVal | input | WIDTH | Load data |
| operand | input | WIDTH | Accumulator operand |
| result | output | WIDTH | Registered result |
| combResult | output | WIDTH | Unregistered chain output |
| carryOut | output | 1 | Final carry of the chain |

## Verification
Clear, load, counting and accumulating can all be requested in the same cycle, and only one of them may take effect. The stimulus table contains a cycle that raises clear, load and count together, a cycle that raises load together with count, and a cycle that raises count together with accumulate. In each case the register value after the edge is compared with the value the priority order gives. The randomised phase draws every control independently and judges each edge against a wide-integer model that applies the same order.

// File: rtl/cscPkg.sv
package cscPkg;
  typedef struct packed {
    logic doClr;
    logic doLoad;
    logic doStep;
    logic useOperand;
    logic invertB;
    logic carryIn;
  } cscStrobes_t;
endpackage

// File: rtl/cscSlice.sv
module cscSlice (
  input  logic a,
  input  logic b,
  input  logic carryIn,
  input  logic lineIn0,
  input  logic lineIn1,
  output logic sum,
  output logic lineOut0,
  output logic lineOut1
);
  logic genIfZero, genIfOne;

  always_comb begin
    genIfZero = a & b;
    genIfOne  = a | b;
    lineOut0  = lineIn0 ? genIfOne : genIfZero;
    lineOut1  = lineIn1 ? genIfOne : genIfZero;
    sum       = a ^ b ^ (carryIn ? lineIn1 : lineIn0);
  end

  // R1: the line that assumes carry 1 never sits below the line that assumes carry 0
  always_comb begin
    if (!$isunknown({a, b, lineIn0, lineIn1}) && !(lineIn0 && !lineIn1))
      assert_line_order_R1: assert (!(lineOut0 && !lineOut1));
  end
endmodule

// File: rtl/cscChain.sv
module cscChain #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);
  logic [WIDTH:0] line0;
  logic [WIDTH:0] line1;

  assign line0[0] = 1'b0;
  assign line1[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : gSlice
    cscSlice slice_i (
      .a        (opA[i]),
      .b        (opB[i]),
      .carryIn  (carryIn),
      .lineIn0  (line0[i]),
      .lineIn1  (line1[i]),
      .sum      (sum[i]),
      .lineOut0 (line0[i+1]),
      .lineOut1 (line1[i+1])
    );
  end

  assign carryOut = carryIn ? line1[WIDTH] : line0[WIDTH];
endmodule

// File: rtl/cscCtrl.sv
module cscCtrl
  import cscPkg::*;
(
  input  logic        clk,
  input  logic        asyncClr,
  input  logic        clkEn,
  input  logic        cntEn,
  input  logic        countUp,
  input  logic        accEn,
  input  logic        addSub,
  input  logic        syncClr,
  input  logic        syncLoad,
  output cscStrobes_t strobes
);
  always_comb begin
    strobes.doClr      = clkEn & syncClr;
    strobes.doLoad     = clkEn & ~syncClr & syncLoad;
    strobes.doStep     = clkEn & ~syncClr & ~syncLoad & (cntEn | accEn);
    strobes.useOperand = ~cntEn;
    strobes.invertB    = cntEn ? ~countUp : ~addSub;
    strobes.carryIn    = cntEn ? countUp : ~addSub;
  end

  // R6 R7 R9: at most one register action per edge
  assert_one_action_R9: assert property (@(posedge clk) disable iff (asyncClr)
    $onehot0({strobes.doClr, strobes.doLoad, strobes.doStep}));

  // R8: nothing is requested while the clock enable is low
  assert_gated_R8: assert property (@(posedge clk) disable iff (asyncClr)
    !clkEn |-> !(strobes.doClr || strobes.doLoad || strobes.doStep));
endmodule

// File: rtl/cscDatapath.sv
module cscDatapath
  import cscPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             asyncClr,
  input  cscStrobes_t      strobes,
  input  logic [WIDTH-1:0] loadVal,
  input  logic [WIDTH-1:0] operand,
  output logic [WIDTH-1:0] result,
  output logic [WIDTH-1:0] combResult,
  output logic             carryOut
);
  logic [WIDTH-1:0] qReg;
  logic [WIDTH-1:0] opB;

  always_comb begin
    opB = (strobes.useOperand ? operand : '0) ^ {WIDTH{strobes.invertB}};
  end

  cscChain #(.WIDTH(WIDTH)) chain_i (
    .opA      (qReg),
    .opB      (opB),
    .carryIn  (strobes.carryIn),
    .sum      (combResult),
    .carryOut (carryOut)
  );

  always_ff @(posedge clk or posedge asyncClr) begin
    if (asyncClr)            qReg <= '0;
    else if (strobes.doClr)  qReg <= '0;
    else if (strobes.doLoad) qReg <= loadVal;
    else if (strobes.doStep) qReg <= combResult;
  end

  assign result = qReg;

  assert_async_clear_R10: assert property (@(posedge clk)
    asyncClr |-> result == '0);
  assert_sync_clear_R6: assert property (@(posedge clk) disable iff (asyncClr)
    strobes.doClr |=> result == '0);
  assert_load_R7: assert property (@(posedge clk) disable iff (asyncClr)
    strobes.doLoad |=> result == $past(loadVal));
  assert_step_R5: assert property (@(posedge clk) disable iff (asyncClr)
    strobes.doStep |=> result == $past(combResult));
  assert_hold_R8: assert property (@(posedge clk) disable iff (asyncClr)
    !(strobes.doClr || strobes.doLoad || strobes.doStep) |=> $stable(result));
endmodule

// File: rtl/cscAccumCounter.sv
module cscAccumCounter
  import cscPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             asyncClr,
  input  logic             clkEn,
  input  logic             cntEn,
  input  logic             countUp,
  input  logic             accEn,
  input  logic             addSub,
  input  logic             syncClr,
  input  logic             syncLoad,
  input  logic [WIDTH-1:0] loadVal,
  input  logic [WIDTH-1:0] operand,
  output logic [WIDTH-1:0] result,
  output logic [WIDTH-1:0] combResult,
  output logic             carryOut
);
  cscStrobes_t strobes;

  cscCtrl ctrl_i (
    .clk      (clk),
    .asyncClr (asyncClr),
    .clkEn    (clkEn),
    .cntEn    (cntEn),
    .countUp  (countUp),
    .accEn    (accEn),
    .addSub   (addSub),
    .syncClr  (syncClr),
    .syncLoad (syncLoad),
    .strobes  (strobes)
  );

  cscDatapath #(.WIDTH(WIDTH)) dp_i (
    .clk        (clk),
    .asyncClr   (asyncClr),
    .strobes    (strobes),
    .loadVal    (loadVal),
    .operand    (operand),
    .result     (result),
    .combResult (combResult),
    .carryOut   (carryOut)
  );
endmodule

// File: tb/cscAccumCounter_tb.sv
module cscAccumCounter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NVEC = 11;

  typedef struct packed {
    logic       clr;
    logic       ld;
    logic       cnt;
    logic       up;
    logic       acc;
    logic       add;
    logic [7:0] ldv;
    logic [7:0] opd;
    logic [7:0] expQ;
  } vec_t;

  // Directed sequence with hand-derived register values after each edge
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hF0, 8'h00, 8'hF0},  // R7 load
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'hF1},  // R4 up
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h20, 8'h11},  // R2 add, carry
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h12, 8'hFF},  // R3 borrow
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00},  // R11 wrap up
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'hFF},  // R11 wrap down
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h33, 8'h00, 8'h00},  // R6 clear wins
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h7F, 8'h00, 8'h7F},  // R7 load wins
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h05, 8'h80},  // R9 count wins
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h03, 8'h80},  // R9 hold
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h80, 8'h00}   // R3 equal, no borrow
  };

  logic clk = 1'b0;
  logic asyncClr, clkEn, cntEn, countUp, accEn, addSub, syncClr, syncLoad;
  logic [W-1:0] loadVal, operand, result, combResult;
  logic carryOut;
  int checks = 0;
  int errors = 0;
  logic [W-1:0] modelQ;

  always #(CLK_PERIOD/2) clk = ~clk;

  cscAccumCounter #(.WIDTH(W)) dut_i (
    .clk(clk), .asyncClr(asyncClr), .clkEn(clkEn), .cntEn(cntEn), .countUp(countUp),
    .accEn(accEn), .addSub(addSub), .syncClr(syncClr), .syncLoad(syncLoad),
    .loadVal(loadVal), .operand(operand), .result(result),
    .combResult(combResult), .carryOut(carryOut)
  );

  function automatic logic [W:0] chainModel(logic [W-1:0] q, logic c, logic u,
                                            logic a, logic [W-1:0] op);
    logic [31:0] t;
    if (c) t = u ? 32'(q) + 32'd1 : 32'(q) + 32'((1 << W) - 1);
    else   t = a ? 32'(q) + 32'(op) : 32'(q) + 32'(((1 << W) - 1) ^ int'(op)) + 32'd1;
    return t[W:0];
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Check chain outputs before the edge, then the register after it
  task automatic stepAndCheck(string req);
    logic [W:0] m;
    logic [W-1:0] nextQ;
    #1;
    m = chainModel(modelQ, cntEn, countUp, addSub, operand);
    chk({req, " comb R1 R2 R3 R4"}, 16'(combResult), 16'(m[W-1:0]));
    chk({req, " carry R1 R2 R3 R4"}, 16'(carryOut), 16'(m[W]));
    if (!clkEn)         nextQ = modelQ;
    else if (syncClr)   nextQ = '0;
    else if (syncLoad)  nextQ = loadVal;
    else if (cntEn || accEn) nextQ = m[W-1:0];
    else                nextQ = modelQ;
    @(posedge clk);
    @(negedge clk);
    modelQ = nextQ;
    chk({req, " result R5"}, 16'(result), 16'(modelQ));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    asyncClr = 1'b1; clkEn = 1'b0; cntEn = 1'b0; countUp = 1'b0; accEn = 1'b0;
    addSub = 1'b0; syncClr = 1'b0; syncLoad = 1'b0; loadVal = '0; operand = '0;
    modelQ = '0;
    repeat (3) @(negedge clk);
    chk("reset R10", 16'(result), 16'h0);
    asyncClr = 1'b0;
    clkEn = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      syncClr = VECS[i].clr; syncLoad = VECS[i].ld; cntEn = VECS[i].cnt;
      countUp = VECS[i].up; accEn = VECS[i].acc; addSub = VECS[i].add;
      loadVal = VECS[i].ldv; operand = VECS[i].opd;
      stepAndCheck($sformatf("vec%0d", i));
      chk($sformatf("vec%0d table R6 R7 R9 R11", i), 16'(result), 16'(VECS[i].expQ));
    end

    // R8: clock enable low blocks clear, load and count
    syncClr = 1'b0; syncLoad = 1'b1; loadVal = 8'hA5; cntEn = 1'b0; accEn = 1'b0;
    stepAndCheck("load");
    clkEn = 1'b0; syncClr = 1'b1; syncLoad = 1'b1; cntEn = 1'b1; countUp = 1'b1;
    stepAndCheck("gated");
    chk("gated hold R8", 16'(result), 16'hA5);
    clkEn = 1'b1; syncClr = 1'b0; syncLoad = 1'b0;

    // R4: counting down from zero gives no carry
    syncClr = 1'b1; cntEn = 1'b0;
    stepAndCheck("clr");
    syncClr = 1'b0; cntEn = 1'b1; countUp = 1'b0;
    #1;
    chk("down from zero carry R4", 16'(carryOut), 16'h0);
    stepAndCheck("downzero");

    // R10: asynchronous clear between edges
    syncLoad = 1'b1; loadVal = 8'h55; cntEn = 1'b0;
    stepAndCheck("preload");
    syncLoad = 1'b0;
    #2 asyncClr = 1'b1;
    #1 chk("async mid-cycle R10", 16'(result), 16'h0);
    @(negedge clk);
    asyncClr = 1'b0;
    modelQ = '0;

    // Randomised controls and operands against the wide-integer model
    for (int k = 0; k < 400; k++) begin
      clkEn    = ($urandom % 8) != 0;
      syncClr  = ($urandom % 16) == 0;
      syncLoad = ($urandom % 10) == 0;
      cntEn    = ($urandom % 2) == 0;
      countUp  = $urandom % 2;
      accEn    = ($urandom % 4) != 0;
      addSub   = $urandom % 2;
      loadVal  = W'($urandom);
      operand  = W'($urandom);
      stepAndCheck($sformatf("rand%0d", k));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule